// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through a small set of programmable large-block mappings before any page-table walk is tried. It holds two independent sets of four mappings, one used for instruction fetches and one for data accesses. Each mapping is a pair of 32-bit words. The upper word carries the block tag, a variable block-length mask and two privilege enables. The lower word carries the real block base and a two-bit protection field.

On every lookup all four entries of the selected set are compared at once, and the lowest-numbered matching entry wins. One cycle later the block reports one of three outcomes: a hit with the translated real address and its read/write rights, a protection fault when the winning entry refuses the requested access, or a plain miss. A miss hands the access to a downstream segment or page-table unit.

A write port loads either word of any entry. Loading an upper word also clears the page-index bits that its block mask covers, in both that upper word and its paired lower word.

Top module: `blk_xlate_unit`

## Requirements
- R1: After reset every entry of both sets is zero. Every lookup then misses, and res_valid, res_hit, res_miss and res_fault are 0 until a lookup is presented.
- R2: An entry's tag matches when ea[31:28] equals upper[31:28], and ea[27:17] with the mask bits cleared equals upper[27:17]. The mask is upper[12:2], applied to ea bits 27:17.
- R3: A tag-matching entry is usable only if upper[1] is set for a supervisor lookup (lk_user=0), or upper[0] is set for a user lookup (lk_user=1).
- R4: The translated address is made up as follows. Bits 31:28 come from lower[31:28]. Bits 27:17 are (ea[27:17] AND mask) OR lower[27:17]. Bits 16:0 are taken from ea unchanged.
- R5: The rights come from lower[1:0]. If bit 1 is set, both read and write are allowed (res_rd_ok=res_wr_ok=1). If the field is 01, only read is allowed. If it is 00, neither is allowed.
- R6: A lookup that hits but requests a right the entry lacks (a write when res_wr_ok=0, or a read when res_rd_ok=0) sets res_fault together with res_hit. A lookup with no usable entry sets res_miss, and res_ra reads 0.
- R7: When several entries are usable, the lowest-numbered one supplies the address and the rights.
- R8: lk_side selects the set (0 instruction, 1 data) and wr_side selects the set that is written. A write to one set never changes the lookups of the other set.
- R9: Writing an upper word (wr_upper=1) stores data[12:0], plus data[31:17] only where the new mask bits are zero. Bits 16:13 are stored as 0.
- R10: Writing an upper word also rewrites the paired lower word. Its bits 0,1,3,4,5,6 are kept, bits 16:7 and bit 2 are cleared, and bits 31:17 are kept only where the new mask is zero. A lower-word write (wr_upper=0) stores the data unchanged.
- R11: The results of a lookup presented in one cycle appear on the outputs after the next rising clock edge, flagged by res_valid. A write takes effect for lookups that start after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_side | input | 1 | Written set: 0 instruction, 1 data |
| wr_upper | input | 1 | 1 writes the upper word, 0 writes the lower word |
| wr_idx | input | 2 | Entry number written |
| wr_data | input | 32 | Write value |
| lk_valid | input | 1 | Lookup request |
| lk_side | input | 1 | Looked-up set: 0 instruction, 1 data |
| lk_user | input | 1 | 1 for user state, 0 for supervisor |
| lk_write | input | 1 | 1 when the access is a store |
| lk_ea | input | 32 | Effective address |
| res_valid | output | 1 | Results below belong to the previous cycle's lookup |
| res_hit | output | 1 | A usable entry was found |
| res_miss | output | 1 | No usable entry |
| res_fault | output | 1 | Hit, but the access is not permitted |
| res_ra | output | 32 | Translated real address (0 on miss) |
| res_rd_ok | output | 1 | Winning entry allows reads |
| res_wr_ok | output | 1 | Winning entry allows writes |

## Verification
Directed lookups separate the main cases: an exact tag with a zero mask, a full mask whose written tag bits must be dropped, supervisor against user enables, and the same address on the two sets. Two overlapping entries with different rights tell whether priority goes to the lowest entry, and a write to a read-only block tells a fault apart from a miss. Random traffic then mixes random writes with addresses built to fall inside a stored block, and with fully random addresses that mostly miss. A bench model checks every outcome field and the full real address.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned BLK_LSB  = 17;
  localparam int unsigned BLK_MSB  = 27;
  localparam int unsigned BLK_W    = BLK_MSB - BLK_LSB + 1;
  localparam int unsigned NSIDES   = 2;
  localparam logic [ADDR_W-1:0] UPR_KEEP = 32'h0000_1FFF;
  localparam logic [ADDR_W-1:0] LWR_KEEP = 32'h0000_007B;
  localparam logic [ADDR_W-1:0] HI_FIELD = 32'hFFFE_0000;

  typedef struct packed {
    logic rd;
    logic wr;
  } perm_t;
endpackage

// File: rtl/bxl_regs.sv
module bxl_regs
  import bxl_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        wr_en,
  input  logic                                        wr_side,
  input  logic                                        wr_upper,
  input  logic [IDX_W-1:0]                            wr_idx,
  input  logic [ADDR_W-1:0]                           wr_data,
  output logic [NSIDES-1:0][N_ENT-1:0][ADDR_W-1:0]    upr_q,
  output logic [NSIDES-1:0][N_ENT-1:0][ADDR_W-1:0]    lwr_q
);
  logic [NSIDES-1:0][N_ENT-1:0][ADDR_W-1:0] upr_d, lwr_d;
  logic [ADDR_W-1:0] new_mask;

  assign new_mask = {{(ADDR_W-BLK_MSB-1){1'b0}}, wr_data[12:2], {BLK_LSB{1'b0}}};

  always_comb begin
    upr_d = upr_q;
    lwr_d = lwr_q;
    if (wr_en) begin
      if (wr_upper) begin
        upr_d[wr_side][wr_idx] = (wr_data & UPR_KEEP) | (wr_data & HI_FIELD & ~new_mask);
        lwr_d[wr_side][wr_idx] = (lwr_q[wr_side][wr_idx] & LWR_KEEP)
                               | (lwr_q[wr_side][wr_idx] & HI_FIELD & ~new_mask);
      end else begin
        lwr_d[wr_side][wr_idx] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upr_q <= '0;
      lwr_q <= '0;
    end else if (wr_en) begin
      upr_q <= upr_d;
      lwr_q <= lwr_d;
    end
  end

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      // R9 R10
      upr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_upper && wr_side == s[0] && wr_idx == e[IDX_W-1:0])
        |=> (upr_q[s][e][16:13] == 4'h0 && lwr_q[s][e][16:7] == 10'h0 && !lwr_q[s][e][2]));
    end
  end
endmodule

// File: rtl/bxl_match.sv
module bxl_match
  import bxl_pkg::*;
(
  input  logic [ADDR_W-1:0]          upr,
  input  logic [ADDR_W-1:0]          lwr,
  input  logic [ADDR_W-1:0]          ea,
  input  logic                       user,
  output logic                       usable,
  output logic [ADDR_W-1:PAGE_LSB]   ra_page,
  output perm_t                      perm
);
  logic [BLK_W-1:0] blen;
  logic             tag_ok, priv_ok;

  assign blen    = upr[12:2];
  assign tag_ok  = (ea[31:28] == upr[31:28]) &&
                   ((ea[BLK_MSB:BLK_LSB] & ~blen) == upr[BLK_MSB:BLK_LSB]);
  assign priv_ok = user ? upr[0] : upr[1];
  assign usable  = tag_ok && priv_ok;
  assign ra_page = {lwr[31:28],
                    (ea[BLK_MSB:BLK_LSB] & blen) | lwr[BLK_MSB:BLK_LSB],
                    ea[BLK_LSB-1:PAGE_LSB]};
  assign perm.wr = lwr[1];
  assign perm.rd = lwr[1] | lwr[0];
endmodule

// File: rtl/bxl_pick.sv
module bxl_pick #(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] req,
  output logic [N_ENT-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = i[IDX_W-1:0];
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/blk_xlate_unit.sv
module blk_xlate_unit
  import bxl_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_side,
  input  logic              wr_upper,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              lk_valid,
  input  logic              lk_side,
  input  logic              lk_user,
  input  logic              lk_write,
  input  logic [31:0]       lk_ea,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_fault,
  output logic [31:0]       res_ra,
  output logic              res_rd_ok,
  output logic              res_wr_ok
);
  logic [NSIDES-1:0][N_ENT-1:0][ADDR_W-1:0] upr_q, lwr_q;
  logic [N_ENT-1:0]                         usable, grant;
  logic [N_ENT-1:0][ADDR_W-1:PAGE_LSB]      pages;
  perm_t [N_ENT-1:0]                        perms;
  logic [IDX_W-1:0]                         win;
  logic                                     any;

  bxl_regs #(.N_ENT(N_ENT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
    .upr_q(upr_q), .lwr_q(lwr_q)
  );

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    bxl_match u_match (
      .upr(upr_q[lk_side][e]), .lwr(lwr_q[lk_side][e]), .ea(lk_ea),
      .user(lk_user), .usable(usable[e]), .ra_page(pages[e]), .perm(perms[e])
    );
  end

  bxl_pick #(.N_ENT(N_ENT)) u_pick (
    .req(usable), .grant(grant), .idx(win), .any(any)
  );

  logic        vld_d, hit_d, miss_d, flt_d;
  logic [31:0] ra_d;
  perm_t       perm_d;

  always_comb begin
    perm_d = any ? perms[win] : '0;
    ra_d   = any ? {pages[win], lk_ea[PAGE_LSB-1:0]} : '0;
    vld_d  = lk_valid;
    hit_d  = lk_valid && any;
    miss_d = lk_valid && !any;
    flt_d  = lk_valid && any && (lk_write ? !perm_d.wr : !perm_d.rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= vld_d;
      res_hit   <= hit_d;
      res_miss  <= miss_d;
      res_fault <= flt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ra    <= '0;
      res_rd_ok <= 1'b0;
      res_wr_ok <= 1'b0;
    end else if (lk_valid) begin
      res_ra    <= ra_d;
      res_rd_ok <= perm_d.rd;
      res_wr_ok <= perm_d.wr;
    end
  end

  // R7
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (usable != '0)));
  // R6
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> (res_hit && !res_miss));
  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && any) |=> (res_ra[PAGE_LSB-1:0] == $past(lk_ea[PAGE_LSB-1:0])));
  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit ^ res_miss));
  // R11
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
endmodule

// File: tb/blk_xlate_unit_tb.sv
module blk_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_side, wr_upper;
  logic [1:0]  wr_idx;
  logic [31:0] wr_data;
  logic        lk_valid, lk_side, lk_user, lk_write;
  logic [31:0] lk_ea;
  logic        res_valid, res_hit, res_miss, res_fault, res_rd_ok, res_wr_ok;
  logic [31:0] res_ra;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_u [2][4];
  logic [31:0] m_l [2][4];

  always #4 clk = ~clk;

  blk_xlate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_side(lk_side), .lk_user(lk_user),
    .lk_write(lk_write), .lk_ea(lk_ea), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
    .res_ra(res_ra), .res_rd_ok(res_rd_ok), .res_wr_ok(res_wr_ok)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [31:0] u);
    return {4'h0, u[12:2], 17'h0};
  endfunction

  task automatic do_write(input bit side, input bit upper, input int idx, input logic [31:0] v);
    logic [31:0] m;
    wr_en = 1; wr_side = side; wr_upper = upper; wr_idx = idx[1:0]; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    if (upper) begin
      m = mask_of(v);
      m_u[side][idx] = (v & 32'h1FFF) | (v & 32'hFFFE_0000 & ~m);
      m_l[side][idx] = (m_l[side][idx] & 32'h7B) | (m_l[side][idx] & 32'hFFFE_0000 & ~m);
    end else begin
      m_l[side][idx] = v;
    end
  endtask

  task automatic do_lookup(input bit side, input bit user, input bit wr,
                           input logic [31:0] ea, input string req);
    logic [36:0] exp, act;
    logic [31:0] u, l, m, ra;
    bit hit, rd, wp, flt;
    hit = 0; rd = 0; wp = 0; ra = 0;
    for (int i = 0; i < 4; i++) begin
      u = m_u[side][i]; l = m_l[side][i]; m = mask_of(u);
      if (!hit && ea[31:28] == u[31:28] && ((ea & ~m & 32'h0FFE_0000) == (u & 32'h0FFE_0000))
          && (user ? u[0] : u[1])) begin
        hit = 1;
        ra  = (l & 32'hF000_0000) | (ea & m) | (l & 32'h0FFE_0000) | (ea & 32'h0001_FFFF);
        wp  = l[1];
        rd  = l[1] | l[0];
      end
    end
    flt = hit && (wr ? !wp : !rd);
    exp = {hit, !hit, flt, rd, wp, ra};
    lk_valid = 1; lk_side = side; lk_user = user; lk_write = wr; lk_ea = ea;
    @(negedge clk);
    lk_valid = 0;
    act = {res_hit, res_miss, res_fault, res_rd_ok, res_wr_ok, res_ra};
    chk(res_valid && act == exp, req, {27'h0, act}, {27'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, base;
    for (int s = 0; s < 2; s++) for (int i = 0; i < 4; i++) begin m_u[s][i] = 0; m_l[s][i] = 0; end
    void'($urandom(32'h5EED_0017));
    rst_n = 0; wr_en = 0; wr_side = 0; wr_upper = 0; wr_idx = 0; wr_data = 0;
    lk_valid = 0; lk_side = 0; lk_user = 0; lk_write = 0; lk_ea = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({res_valid, res_hit, res_miss, res_fault} == 4'b0, "R1",
        {60'h0, res_valid, res_hit, res_miss, res_fault}, 64'h0);
    do_lookup(1, 0, 0, 32'h0000_0000, "R1");
    do_lookup(0, 1, 0, 32'h0000_1234, "R1");
    // R2 R4 R5 exact tag, supervisor entry, read/write
    do_write(1, 0, 2, 32'h1234_0002);
    do_write(1, 1, 2, 32'h8000_0002);
    do_lookup(1, 0, 1, 32'h8000_5ABC, "R4");
    do_lookup(1, 0, 0, 32'h8002_0000, "R2");
    // R3 user state not enabled
    do_lookup(1, 1, 0, 32'h8000_5ABC, "R3");
    // R8 other set untouched
    do_lookup(0, 0, 0, 32'h8000_5ABC, "R8");
    // R7 lower entry wins, read-only, store faults (R6)
    do_write(1, 0, 1, 32'h5550_0001);
    do_write(1, 1, 1, 32'h8000_0003);
    do_lookup(1, 0, 0, 32'h8000_0ABC, "R7");
    do_lookup(1, 1, 1, 32'h8000_0ABC, "R6");
    // R9 R10 full mask, tag bits dropped, lower bits cleared
    do_write(0, 0, 0, 32'hFFFE_FFFF);
    do_write(0, 1, 0, 32'h9FFE_1FFD);
    do_lookup(0, 1, 1, 32'h9ABC_DEF0, "R9");
    do_lookup(0, 1, 0, 32'h9000_0010, "R10");
    // R5 no-access block after lower write
    do_write(0, 0, 0, 32'h0000_0000);
    do_lookup(0, 1, 0, 32'h9ABC_DEF0, "R5");
    // R11 back-to-back
    do_lookup(0, 1, 0, 32'h9123_4567, "R11");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      r = $urandom;
      if (r[1:0] == 2'b00) begin
        do_write(r[2], r[3], int'(r[5:4]), $urandom);
      end else begin
        base = m_u[r[2]][r[5:4]];
        if (r[6]) lk_ea = (base & 32'hFFFE_0000) | ($urandom & (mask_of(base) | 32'h1FFFF));
        else      lk_ea = $urandom;
        do_lookup(r[2], r[7], r[8], lk_ea, r[6] ? "R2" : "R6");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule